// File: doc/BRIEF.md
# Coprocessor Interrupt Latch Controller

This block holds the control and flags registers that govern interrupts for a small RISC coprocessor. The control register carries a run bit, a fixed version field and six interrupt latches. The flags register carries the six interrupt enables, a global mask bit and a set of write-only latch-clear bits. Six external interrupt lines drive the latches. A rising line sets its latch and a falling line clears it.

Software can write both registers. A write to the control register cannot disturb the version field or any latch. Latches 0 to 4 are cleared through clear bits in a flags write. Latch 5 sits apart from the others in the control word, and no clear bit reaches it. The block computes a pending vector as the latches masked by their enables, and it presents the highest-numbered pending interrupt as a request. The request is held back while the global mask is set.

Top module: `cop_irq_ctrl`

## Requirements
- R1: After reset, ctlReg reads 0x00002000, which is version 2 in bits 15:12. flagReg reads 0, pendVec reads 0 and reqValid is 0.
- R2: A 0-to-1 change on irqLines[n] sets latch n at the next clock edge. Latches 0 to 4 are ctlReg bits 10:6, and latch 5 is ctlReg bit 15.
- R3: A 1-to-0 change on irqLines[n] clears latch n at the next clock edge. A line that holds its level leaves its latch unchanged.
- R4: A flags write with bit k set, for k in 13:9, clears latch k-9, which is ctlReg bit k-3. Flags bits 13:9 always read back as 0. Every other flags bit stores the written value.
- R5: When a rising line and a clear of the same latch arrive in the same cycle, the latch ends set.
- R6: A control write keeps ctlReg bits 15:12 and 10:6 unchanged and takes every other bit, including run bit 0 and bit 11, from wrData.
- R7: pendVec[n] equals latch n AND enable n. Enables 0 to 4 are flagReg bits 8:4, and enable 5 is flagReg bit 16.
- R8: reqId gives the highest-numbered set bit of pendVec. reqValid is 1 when pendVec is nonzero and flagReg bit 3 is 0.
- R9: While flagReg bit 3 is 1, reqValid is 0 and pendVec is unaffected.
- R10: Flags clear bits never clear latch 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlWrEn | input | 1 | Write wrData to the control register |
| flagWrEn | input | 1 | Write wrData to the flags register |
| wrData | input | 32 | Write data |
| irqLines | input | 6 | External interrupt lines |
| ctlReg | output | 32 | Control register value |
| flagReg | output | 32 | Flags register value |
| pendVec | output | 6 | Latches ANDed with enables |
| reqValid | output | 1 | An unmasked interrupt is pending |
| reqId | output | 3 | Highest-numbered pending interrupt |

## Verification
The hardest case to reach from the ports is a latch clear that lands in the same cycle as a rising edge on that same line. To build it, the bench first lowers all lines so that the latch is empty. It then applies the rising line and the flags clear write at a single clock edge. Clearing latches with the lines held high is just as deliberate: with no edge present, a clear bit is the only thing that can change a latch.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_IRQ  = 6;
  localparam int ID_W     = $clog2(NUM_IRQ);
  localparam int LOW_IRQS = 5;
  localparam int LATCH_LO = 6;
  localparam int LATCH_HI = 15;
  localparam int EN_LO    = 4;
  localparam int EN_HI    = 16;
  localparam int CLR_LO   = 9;
  localparam int MASK_BIT = 3;
  localparam logic [DATA_W-1:0] CTL_RESET = 32'h0000_2000;
  localparam logic [DATA_W-1:0] VER_MASK  = 32'h0000_F000;
  localparam logic [DATA_W-1:0] LAT_MASK  = 32'h0000_87C0;
  localparam logic [DATA_W-1:0] PROT_MASK = VER_MASK | LAT_MASK;
  localparam logic [DATA_W-1:0] CLR_FIELD = 32'h0000_3E00;

  typedef struct packed {
    logic [NUM_IRQ-1:0] setMask;
    logic [NUM_IRQ-1:0] clrMask;
    logic               ctlWrite;
    logic               flagWrite;
  } irqStrobeT;

  function automatic int latchPos(input int n);
    return (n < LOW_IRQS) ? LATCH_LO + n : LATCH_HI;
  endfunction

  function automatic int enablePos(input int n);
    return (n < LOW_IRQS) ? EN_LO + n : EN_HI;
  endfunction
endpackage

// File: rtl/cop_irq_ctl.sv
module cop_irq_ctl
  import cop_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic              flagWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic              maskOn,
  output irqStrobeT         strb,
  output logic              reqValid,
  output logic [ID_W-1:0]   reqId
);
  logic [NUM_IRQ-1:0] irqPrev;
  logic [NUM_IRQ-1:0] swClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqLines;
  end

  always_comb begin
    swClr = '0;
    if (flagWrEn) swClr[LOW_IRQS-1:0] = wrData[CLR_LO +: LOW_IRQS];
    strb.setMask   = irqLines & ~irqPrev;
    strb.clrMask   = (~irqLines & irqPrev) | swClr;
    strb.ctlWrite  = ctlWrEn;
    strb.flagWrite = flagWrEn;
  end

  always_comb begin
    reqId = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (pendVec[i]) reqId = ID_W'(i);
    reqValid = (|pendVec) && !maskOn;
  end

  assert_req_highest_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((pendVec >> reqId) == NUM_IRQ'(1)));
  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    maskOn |-> !reqValid);
endmodule

// File: rtl/cop_irq_dp.sv
module cop_irq_dp
  import cop_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctlReg,
  output logic [DATA_W-1:0] flagReg,
  output logic [NUM_IRQ-1:0] pendVec,
  output logic              maskOn
);
  logic [DATA_W-1:0]  ctlNext;
  logic [NUM_IRQ-1:0] latchVec;
  logic [NUM_IRQ-1:0] enVec;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : gMap
      assign latchVec[g] = ctlReg[latchPos(g)];
      assign enVec[g]    = flagReg[enablePos(g)];
    end
  endgenerate

  always_comb begin
    ctlNext = strb.ctlWrite ? ((ctlReg & PROT_MASK) | (wrData & ~PROT_MASK)) : ctlReg;
    for (int i = 0; i < NUM_IRQ; i++)
      ctlNext[latchPos(i)] = (latchVec[i] & ~strb.clrMask[i]) | strb.setMask[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= CTL_RESET;
      flagReg <= '0;
    end else begin
      ctlReg <= ctlNext;
      if (strb.flagWrite) flagReg <= wrData & ~CLR_FIELD;
    end
  end

  assign pendVec = latchVec & enVec;
  assign maskOn  = flagReg[MASK_BIT];

  assert_version_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ctlReg[14:12]));
  assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask != '0) |=> ((latchVec & $past(strb.setMask)) == $past(strb.setMask)));
  assert_latch_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.clrMask & ~strb.setMask) != '0) |=>
      ((latchVec & $past(strb.clrMask & ~strb.setMask)) == '0));
  assert_clear_field_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg & CLR_FIELD) == '0);
endmodule

// File: rtl/cop_irq_ctrl.sv
module cop_irq_ctrl
  import cop_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic              flagWrEn,
  input  logic [31:0]       wrData,
  input  logic [5:0]        irqLines,
  output logic [31:0]       ctlReg,
  output logic [31:0]       flagReg,
  output logic [5:0]        pendVec,
  output logic              reqValid,
  output logic [2:0]        reqId
);
  irqStrobeT strb;
  logic      maskOn;

  cop_irq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .flagWrEn(flagWrEn),
    .wrData(wrData), .irqLines(irqLines), .pendVec(pendVec), .maskOn(maskOn),
    .strb(strb), .reqValid(reqValid), .reqId(reqId)
  );

  cop_irq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .ctlReg(ctlReg), .flagReg(flagReg), .pendVec(pendVec), .maskOn(maskOn)
  );
endmodule

// File: tb/cop_irq_ctrl_tb_top.sv
module cop_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic        flagWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [5:0]  irqLines = '0;
  logic [31:0] ctlReg, flagReg;
  logic [5:0]  pendVec;
  logic        reqValid;
  logic [2:0]  reqId;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cop_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .flagWrEn(flagWrEn),
    .wrData(wrData), .irqLines(irqLines), .ctlReg(ctlReg), .flagReg(flagReg),
    .pendVec(pendVec), .reqValid(reqValid), .reqId(reqId)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ctlWrEn  = 1'b0;
    flagWrEn = 1'b0;
  endtask

  task automatic setLines(input logic [5:0] v);
    irqLines = v;
    step();
  endtask

  task automatic writeFlags(input logic [31:0] d);
    flagWrEn = 1'b1; wrData = d;
    step();
  endtask

  task automatic writeCtl(input logic [31:0] d);
    ctlWrEn = 1'b1; wrData = d;
    step();
  endtask

  task automatic testReset();
    chk("R1 ctl", ctlReg, 32'h2000);
    chk("R1 flags", flagReg, 0);
    chk("R1 pend", {26'd0, pendVec}, 0);
    chk("R1 req", {31'd0, reqValid}, 0);
  endtask

  task automatic testEdges();
    setLines(6'b000001);
    chk("R2 latch0", ctlReg, 32'h2040);
    setLines(6'b100001);
    chk("R2 latch5", ctlReg, 32'hA040);
    setLines(6'b000001);
    chk("R3 fall5", ctlReg, 32'h2040);
    step();
    chk("R3 steady", ctlReg, 32'h2040);
  endtask

  task automatic testPending();
    writeFlags(32'h0001_0010);
    chk("R7 pend0", {26'd0, pendVec}, 6'b000001);
    chk("R8 valid", {31'd0, reqValid}, 1);
    chk("R8 id0", {29'd0, reqId}, 0);
    setLines(6'b100001);
    chk("R8 id5", {29'd0, reqId}, 5);
    setLines(6'b101001);
    chk("R7 latch3", ctlReg, 32'hA240);
    chk("R7 unenabled", {26'd0, pendVec}, 6'b100001);
  endtask

  task automatic testMask();
    writeFlags(32'h0001_0018);
    chk("R9 masked", {31'd0, reqValid}, 0);
    chk("R9 pend", {26'd0, pendVec}, 6'b100001);
  endtask

  task automatic testClear();
    writeFlags(32'h0001_1210);
    chk("R4 clear", ctlReg, 32'hA000);
    chk("R4 readback", flagReg, 32'h0001_0010);
    writeFlags(32'h0001_3E10);
    chk("R10 latch5 kept", ctlReg, 32'hA000);
  endtask

  task automatic testSetWins();
    setLines(6'b000000);
    chk("R3 all low", ctlReg, 32'h2000);
    irqLines = 6'b000010;
    writeFlags(32'h0000_0400);
    chk("R5 set wins", ctlReg, 32'h2080);
  endtask

  task automatic testCtlWrite();
    writeCtl(32'hFFFF_FFFF);
    chk("R6 protect", ctlReg, 32'hFFFF_28BF);
    writeCtl(32'h0000_0000);
    chk("R6 run off", ctlReg, 32'h2080);
  endtask

  task automatic testPriority();
    writeFlags(32'h0000_01F0);
    setLines(6'b010010);
    chk("R8 pend", {26'd0, pendVec}, 6'b010010);
    chk("R8 id4", {29'd0, reqId}, 4);
    chk("R8 valid2", {31'd0, reqValid}, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEdges();
    testPending();
    testMask();
    testClear();
    testSetWins();
    testCtlWrite();
    testPriority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule